// File: doc/BRIEF.md
# Bus Clock Prescaler with Gating

This block turns one system clock into a set of clock-enable strobes for the bus domains of a chip. No real clocks are generated. Every output is a one-cycle enable in the system clock domain, and the logic of each bus advances only on the cycles where its strobe is high.

A power-of-two divider sets the main system bus rate as a fraction of the system clock. Two further dividers set the rates of a fast peripheral bus and a slow peripheral bus. Both peripheral dividers count system-bus strobes. Each peripheral bus also produces a timer-tick strobe. The tick runs at the bus rate when that bus is undivided, and at twice the bus rate otherwise.

A mask gates the bus strobe separately for each peripheral. The block also reports how many system cycles one fast-bus cycle and one slow-bus cycle occupy, so that the cost of a bus access can be checked directly. The slow bus can never run faster than half the system-bus rate. A new divider selection waits for the end of the period in progress, so no strobe is ever shortened or merged.

Top module: `bus_prescaler_gate`

## Requirements
- R1: `sys_div_sel` code k (0..9) makes `sys_en` pulse once every 2^k system cycles, and a code of 0 holds it high on every cycle. Codes 10..15 behave as code 9 (one pulse every 512 cycles).
- R2: The slow bus strobe `slow_en` pulses once every 2^c system-bus strobes. Here c is `slow_div_sel` raised to at least 1 and capped at 4. A code of 0 therefore gives half the system-bus rate, and `slow_en` is never high in two consecutive cycles.
- R3: The fast bus strobe `fast_en` pulses once every 2^c system-bus strobes, with c equal to `fast_div_sel` capped at 4. Code 0 passes the system-bus rate through unchanged. Every `fast_en` pulse follows a `sys_en` pulse in the previous cycle.
- R4: On each peripheral bus, the tick strobe is high in every cycle in which the bus strobe is high. When that bus's effective code is above 0, the tick also pulses exactly halfway through each bus period, so the tick period is half the bus period. With code 0, the tick period equals the bus period.
- R5: Bit i of `fast_periph_en` (or of `slow_periph_en`) is high only in a cycle where the bus strobe is high, and only if bit i of `fast_gate` (or `slow_gate`) was 1 at the previous clock edge. A cleared gate bit suppresses every strobe for that peripheral.
- R6: `slow_bus_cycles` equals 2^(system code + effective slow code) and `fast_bus_cycles` equals 2^(system code + effective fast code). Both are given in system cycles per bus cycle. With the system bus undivided and a slow code of 0, `slow_bus_cycles` is 2, so a two-cycle slow-bus access spans 4 system cycles.
- R7: After any selection input changes, the period already in progress on that divider completes at its old length. The new ratio, including the value reported by R6, applies from that boundary onward.
- R8: While `rst_n` is low, every strobe and every gated peripheral enable is 0. After release, the dividers run at their reset setting: system /1, fast /1, slow /2 (the slow minimum). All gates are closed until the mask is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_div_sel | input | 4 | System bus divider code, /2^code |
| fast_div_sel | input | 3 | Fast peripheral bus divider code |
| slow_div_sel | input | 3 | Slow peripheral bus divider code |
| fast_gate | input | 4 | Per-peripheral enable mask, fast bus |
| slow_gate | input | 4 | Per-peripheral enable mask, slow bus |
| sys_en | output | 1 | System bus enable strobe |
| fast_en | output | 1 | Fast bus enable strobe |
| fast_tick | output | 1 | Fast bus timer tick strobe |
| slow_en | output | 1 | Slow bus enable strobe |
| slow_tick | output | 1 | Slow bus timer tick strobe |
| fast_periph_en | output | 4 | Gated fast bus strobe per peripheral |
| slow_periph_en | output | 4 | Gated slow bus strobe per peripheral |
| fast_bus_cycles | output | 14 | System cycles per fast bus cycle |
| slow_bus_cycles | output | 14 | System cycles per slow bus cycle |

## Verification
The collision of interest is a divider reprogramming that lands in the same cycle as a bus boundary, as opposed to one that lands mid-period. The bench provokes both cases on the fast bus. It changes the code on the very cycle a `fast_en` pulse is visible, and again three cycles into a period. In each case it judges the result by the interval to the next strobe, which must have the old length, and by the interval after that, which must have the new length. It also checks that `fast_bus_cycles` still reports the old ratio until the boundary. A near-exhaustive sweep over the divider codes then measures every strobe period against the arithmetic expectation.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  // Limit a divider code to the legal range of one bus.
  function automatic int unsigned clamp_code(input int unsigned sel,
                                             input int unsigned lo,
                                             input int unsigned hi);
    if (sel < lo) return lo;
    if (sel > hi) return hi;
    return sel;
  endfunction

endpackage

// File: rtl/bpg_sys_div.sv
module bpg_sys_div
  import bpg_pkg::*;
#(
  parameter int unsigned MAX_CODE = 9,
  parameter int unsigned SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             en_o,
  output logic [SEL_W-1:0] act_o
);
  localparam int unsigned CNT_W = MAX_CODE + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic [SEL_W-1:0] act;
  logic [SEL_W-1:0] nxt;
  logic             en_q;

  always_comb begin
    nxt  = SEL_W'(clamp_code(32'(sel_i), 0, MAX_CODE));
    last = (CNT_W'(1) << act) - CNT_W'(1);
  end

  // A new code is adopted only on the cycle that closes the current period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      act  <= '0;
      en_q <= 1'b0;
    end else if (cnt == last) begin
      cnt  <= '0;
      act  <= nxt;
      en_q <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      en_q <= 1'b0;
    end
  end

  assign en_o  = en_q;
  assign act_o = act;
endmodule

// File: rtl/bpg_per_div.sv
module bpg_per_div
  import bpg_pkg::*;
#(
  parameter int unsigned MIN_CODE = 0,
  parameter int unsigned MAX_CODE = 4,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned N_PERIPH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                base_en,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [N_PERIPH-1:0] gate_i,
  output logic                bus_o,
  output logic                tick_o,
  output logic [N_PERIPH-1:0] periph_o,
  output logic [SEL_W-1:0]    act_o
);
  localparam int unsigned CNT_W = MAX_CODE + 1;

  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    last;
  logic [CNT_W-1:0]    half_last;
  logic [SEL_W-1:0]    act;
  logic [SEL_W-1:0]    nxt;
  logic                bus_q;
  logic                tick_q;
  logic [N_PERIPH-1:0] gate_q;

  always_comb begin
    nxt       = SEL_W'(clamp_code(32'(sel_i), MIN_CODE, MAX_CODE));
    last      = (CNT_W'(1) << act) - CNT_W'(1);
    half_last = ((CNT_W'(1) << act) >> 1) - CNT_W'(1);
  end

  // Counts base strobes; tick doubles the rate when the divider is above /1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      act    <= SEL_W'(MIN_CODE);
      bus_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      bus_q  <= 1'b0;
      tick_q <= 1'b0;
      if (base_en) begin
        if (cnt == last) begin
          cnt    <= '0;
          act    <= nxt;
          bus_q  <= 1'b1;
          tick_q <= 1'b1;
        end else begin
          cnt    <= cnt + CNT_W'(1);
          tick_q <= (act != '0) && (cnt == half_last);
        end
      end
    end
  end

  // One gate cell per peripheral.
  for (genvar gi = 0; gi < N_PERIPH; gi++) begin : g_gate
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q[gi] <= 1'b0;
      else        gate_q[gi] <= gate_i[gi];
    end
    assign periph_o[gi] = bus_q & gate_q[gi];
  end

  assign bus_o  = bus_q;
  assign tick_o = tick_q;
  assign act_o  = act;
endmodule

// File: rtl/bus_prescaler_gate.sv
module bus_prescaler_gate #(
  parameter int unsigned SYS_MAX_CODE = 9,
  parameter int unsigned PER_MAX_CODE = 4,
  parameter int unsigned N_FAST       = 4,
  parameter int unsigned N_SLOW       = 4,
  localparam int unsigned SYS_SEL_W   = $clog2(SYS_MAX_CODE + 1),
  localparam int unsigned PER_SEL_W   = $clog2(PER_MAX_CODE + 1),
  localparam int unsigned RATIO_W     = SYS_MAX_CODE + PER_MAX_CODE + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SYS_SEL_W-1:0] sys_div_sel,
  input  logic [PER_SEL_W-1:0] fast_div_sel,
  input  logic [PER_SEL_W-1:0] slow_div_sel,
  input  logic [N_FAST-1:0]    fast_gate,
  input  logic [N_SLOW-1:0]    slow_gate,
  output logic                 sys_en,
  output logic                 fast_en,
  output logic                 fast_tick,
  output logic                 slow_en,
  output logic                 slow_tick,
  output logic [N_FAST-1:0]    fast_periph_en,
  output logic [N_SLOW-1:0]    slow_periph_en,
  output logic [RATIO_W-1:0]   fast_bus_cycles,
  output logic [RATIO_W-1:0]   slow_bus_cycles
);
  logic [SYS_SEL_W-1:0] sys_act;
  logic [PER_SEL_W-1:0] fast_act;
  logic [PER_SEL_W-1:0] slow_act;

  bpg_sys_div #(
    .MAX_CODE (SYS_MAX_CODE),
    .SEL_W    (SYS_SEL_W)
  ) u_sys (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_i (sys_div_sel),
    .en_o  (sys_en),
    .act_o (sys_act)
  );

  // Fast bus may run at the full system-bus rate.
  bpg_per_div #(
    .MIN_CODE (0),
    .MAX_CODE (PER_MAX_CODE),
    .SEL_W    (PER_SEL_W),
    .N_PERIPH (N_FAST)
  ) u_fast (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_en  (sys_en),
    .sel_i    (fast_div_sel),
    .gate_i   (fast_gate),
    .bus_o    (fast_en),
    .tick_o   (fast_tick),
    .periph_o (fast_periph_en),
    .act_o    (fast_act)
  );

  // Slow bus is held to at most half the system-bus rate.
  bpg_per_div #(
    .MIN_CODE (1),
    .MAX_CODE (PER_MAX_CODE),
    .SEL_W    (PER_SEL_W),
    .N_PERIPH (N_SLOW)
  ) u_slow (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_en  (sys_en),
    .sel_i    (slow_div_sel),
    .gate_i   (slow_gate),
    .bus_o    (slow_en),
    .tick_o   (slow_tick),
    .periph_o (slow_periph_en),
    .act_o    (slow_act)
  );

  assign fast_bus_cycles = RATIO_W'(1) << (int'(sys_act) + int'(fast_act));
  assign slow_bus_cycles = RATIO_W'(1) << (int'(sys_act) + int'(slow_act));
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
  parameter int unsigned N_FAST  = 4,
  parameter int unsigned N_SLOW  = 4,
  parameter int unsigned RATIO_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sys_en,
  input logic               fast_en,
  input logic               fast_tick,
  input logic               slow_en,
  input logic               slow_tick,
  input logic [N_FAST-1:0]  fast_gate,
  input logic [N_SLOW-1:0]  slow_gate,
  input logic [N_FAST-1:0]  fast_periph_en,
  input logic [N_SLOW-1:0]  slow_periph_en,
  input logic [RATIO_W-1:0] slow_bus_cycles
);

  p_slow_half_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en |=> !slow_en);

  p_fast_follows_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fast_en |-> $past(sys_en));

  p_slow_follows_sys_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en |-> $past(sys_en));

  p_fast_tick_on_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fast_en |-> fast_tick);

  p_slow_tick_on_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en |-> slow_tick);

  p_fast_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_periph_en & ~$past(fast_gate)) == '0);

  p_slow_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_periph_en & ~$past(slow_gate)) == '0);

  p_slow_ratio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(slow_bus_cycles) == 1) && (slow_bus_cycles >= RATIO_W'(2)));

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |=> (fast_periph_en == '0) && (slow_periph_en == '0));

endmodule

bind bus_prescaler_gate bpg_checker #(
  .N_FAST  (N_FAST),
  .N_SLOW  (N_SLOW),
  .RATIO_W (RATIO_W)
) i_bpg_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .sys_en          (sys_en),
  .fast_en         (fast_en),
  .fast_tick       (fast_tick),
  .slow_en         (slow_en),
  .slow_tick       (slow_tick),
  .fast_gate       (fast_gate),
  .slow_gate       (slow_gate),
  .fast_periph_en  (fast_periph_en),
  .slow_periph_en  (slow_periph_en),
  .slow_bus_cycles (slow_bus_cycles)
);

// File: tb/test_bus_prescaler_gate.sv
module test_bus_prescaler_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sys_div_sel = '0;
  logic [2:0]  fast_div_sel = '0;
  logic [2:0]  slow_div_sel = '0;
  logic [3:0]  fast_gate = '0;
  logic [3:0]  slow_gate = '0;
  logic        sys_en, fast_en, fast_tick, slow_en, slow_tick;
  logic [3:0]  fast_periph_en, slow_periph_en;
  logic [13:0] fast_bus_cycles, slow_bus_cycles;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_prescaler_gate i_bus_prescaler_gate (
    .clk (clk), .rst_n (rst_n),
    .sys_div_sel (sys_div_sel), .fast_div_sel (fast_div_sel), .slow_div_sel (slow_div_sel),
    .fast_gate (fast_gate), .slow_gate (slow_gate),
    .sys_en (sys_en), .fast_en (fast_en), .fast_tick (fast_tick),
    .slow_en (slow_en), .slow_tick (slow_tick),
    .fast_periph_en (fast_periph_en), .slow_periph_en (slow_periph_en),
    .fast_bus_cycles (fast_bus_cycles), .slow_bus_cycles (slow_bus_cycles)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit sig(input int w);
    case (w)
      0: return sys_en;
      1: return fast_en;
      2: return fast_tick;
      3: return slow_en;
      default: return slow_tick;
    endcase
  endfunction

  // Interval in cycles between two consecutive highs of a strobe.
  task automatic measure(input int w, output int per);
    @(negedge clk);
    while (!sig(w)) @(negedge clk);
    per = 0;
    do begin
      @(negedge clk);
      per++;
    end while (!sig(w));
  endtask

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    int per;
    int prev_ps;
    int cnt_bus;
    int bad;

    // R8: quiet while in reset
    steps(3);
    check(!sys_en && !fast_en && !slow_en && !fast_tick && !slow_tick, "R8",
          "strobes in reset", int'(sys_en | fast_en | slow_en), 0);
    check(fast_periph_en == 0 && slow_periph_en == 0, "R8", "gated enables in reset",
          int'({fast_periph_en, slow_periph_en}), 0);
    rst_n = 1'b1;
    fast_gate = 4'hF;
    slow_gate = 4'hF;
    steps(4);
    // R8: reset defaults are system /1, fast /1, slow /2
    measure(0, per); check(per == 1, "R8", "sys period after reset", per, 1);
    measure(1, per); check(per == 1, "R8", "fast period after reset", per, 1);
    measure(3, per); check(per == 2, "R8", "slow period after reset", per, 2);
    check(slow_bus_cycles == 2, "R6", "slow cycles after reset", int'(slow_bus_cycles), 2);
    // R6: two-cycle slow access at sys /1, slow /2 spans 4 system cycles
    check(2 * int'(slow_bus_cycles) == 4, "R6", "two-cycle access length",
          2 * int'(slow_bus_cycles), 4);

    // Sweep of divider codes: R1 R2 R3 R4 R6
    prev_ps = 1;
    for (int s = 0; s < 4; s++) begin
      for (int f = 0; f < 5; f++) begin
        for (int l = 0; l < 5; l++) begin
          int ps, pf, pl, tf, tl;
          ps = 1 << s;
          pf = ps << f;
          pl = ps << ((l == 0) ? 1 : l);
          tf = (f == 0) ? pf : pf / 2;
          tl = pl / 2;
          sys_div_sel = 4'(s);
          fast_div_sel = 3'(f);
          slow_div_sel = 3'(l);
          steps(3 * 16 * imax(prev_ps, ps) + 4);
          prev_ps = ps;
          measure(0, per); check(per == ps, "R1", "sys period", per, ps);
          measure(1, per); check(per == pf, "R3", "fast period", per, pf);
          measure(2, per); check(per == tf, "R4", "fast tick period", per, tf);
          measure(3, per); check(per == pl, "R2", "slow period", per, pl);
          measure(4, per); check(per == tl, "R4", "slow tick period", per, tl);
          while (!fast_en) @(negedge clk);
          check(fast_tick, "R4", "fast tick with bus strobe", int'(fast_tick), 1);
          check(int'(fast_bus_cycles) == pf, "R6", "fast cycles", int'(fast_bus_cycles), pf);
          check(int'(slow_bus_cycles) == pl, "R6", "slow cycles", int'(slow_bus_cycles), pl);
        end
      end
    end

    // R1: large system codes, and out-of-range codes behaving as /512
    fast_div_sel = 3'd0;
    slow_div_sel = 3'd1;
    for (int s = 4; s < 11; s++) begin
      int code, ps;
      code = (s == 10) ? 15 : s;
      ps = 1 << ((code > 9) ? 9 : code);
      sys_div_sel = 4'(code);
      steps(3 * 16 * prev_ps + 2 * ps + 4);
      prev_ps = ps;
      measure(0, per); check(per == ps, "R1", "sys period high code", per, ps);
      check(int'(slow_bus_cycles) == 2 * ps, "R6", "slow cycles high code",
            int'(slow_bus_cycles), 2 * ps);
    end

    // R3/R2: peripheral codes above 4 behave as /16
    sys_div_sel = 4'd0;
    fast_div_sel = 3'd7;
    slow_div_sel = 3'd6;
    steps(3 * 16 * prev_ps + 64);
    prev_ps = 1;
    measure(1, per); check(per == 16, "R3", "fast period code 7", per, 16);
    measure(3, per); check(per == 16, "R2", "slow period code 6", per, 16);

    // R7: change on the strobe cycle, then change mid-period
    fast_div_sel = 3'd1;
    slow_div_sel = 3'd1;
    steps(80);
    while (!fast_en) @(negedge clk);
    fast_div_sel = 3'd3;
    per = 0;
    do begin @(negedge clk); per++; end while (!fast_en);
    check(per == 2, "R7", "interval after change on boundary", per, 2);
    per = 0;
    do begin @(negedge clk); per++; end while (!fast_en);
    check(per == 8, "R7", "first interval at new ratio", per, 8);
    per = 0;
    repeat (3) begin @(negedge clk); per++; end
    fast_div_sel = 3'd1;
    @(negedge clk);
    per++;
    check(fast_bus_cycles == 8, "R7", "ratio held until boundary", int'(fast_bus_cycles), 8);
    while (!fast_en) begin @(negedge clk); per++; end
    check(per == 8, "R7", "interval after mid-period change", per, 8);
    measure(1, per); check(per == 2, "R7", "interval at new short ratio", per, 2);
    check(fast_bus_cycles == 2, "R7", "ratio after boundary", int'(fast_bus_cycles), 2);

    // R5: every fast mask, complement on the slow bus
    fast_div_sel = 3'd1;
    slow_div_sel = 3'd2;
    steps(40);
    for (int m = 0; m < 16; m++) begin
      fast_gate = 4'(m);
      slow_gate = ~4'(m);
      steps(2);
      bad = 0;
      cnt_bus = 0;
      for (int c = 0; c < 16; c++) begin
        if (fast_periph_en != (fast_en ? fast_gate : 4'h0)) bad++;
        if (slow_periph_en != (slow_en ? slow_gate : 4'h0)) bad++;
        if (slow_en) cnt_bus++;
        @(negedge clk);
      end
      check(bad == 0, "R5", $sformatf("gating mask %0d mismatched cycles", m), bad, 0);
      check(cnt_bus == 4, "R5", "slow strobes in gating window", cnt_bus, 4);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule